// File: doc/BRIEF.md
# I2C Bus Status and Flag Unit

This unit watches the two wires of an I2C bus after they have been filtered, and turns what it sees into status for the rest of a bus controller. It resynchronises SCL and SDA to its own clock and recognises bus conditions. A START is a falling SDA while SCL stays high, and a STOP is a rising SDA while SCL stays high. From these it keeps a bus-active indication and sets sticky event flags.

The shifter and the waveform generator elsewhere in the controller report further events as one-cycle pulses: a not-acknowledge was received, arbitration was lost, a general-call address was accepted. A level input marks that clock stretching is in progress. Each flag stays set until software clears it through a write-one-to-clear mask, or until the bus condition tied to that flag clears it. The flags are ANDed with per-flag enables and ORed together to form a single interrupt request.

Flag vector bit positions: 0 START seen, 1 STOP seen, 2 not-acknowledge received, 3 arbitration lost, 4 general call accepted.

Top module: `i2cBusStatus`

## Requirements
- R1: A START condition sets `busBusy` and a STOP condition clears it. With two synchronizer stages, the change is visible after the third rising clock edge that follows the SDA transition.
- R2: A START sets flag bit 0 and a STOP sets flag bit 1.
- R3: The START flag (bit 0) clears itself when a STOP is detected.
- R4: The STOP (bit 1), not-acknowledge (bit 2), arbitration-lost (bit 3) and general-call (bit 4) flags clear themselves when a START is detected.
- R5: A one-cycle pulse on `nackEvt`, `arbLostEvt` or `genCallEvt` sets flag bit 2, 3 or 4 respectively, visible after the next rising edge.
- R6: A 1 in `clrMask` clears the matching flag on the next rising edge, and flags whose `clrMask` bit is 0 keep their value.
- R7: When a set event for a flag coincides with a software clear or a self-clear of that flag, the flag ends up set.
- R8: `irq` is high exactly when at least one flag is set and its bit in `intEn` is 1.
- R9: `sclHeldLow` is high when `sclStretch` is active and the synchronized SCL is low, and low otherwise.
- R10: After reset all flags, `busBusy`, `sclHeldLow` and `irq` are 0.
- R11: SDA transitions while SCL is low are not bus conditions: they change neither `busBusy` nor any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Filtered SCL line |
| sdaIn | input | 1 | Filtered SDA line |
| nackEvt | input | 1 | Pulse: not-acknowledge received |
| arbLostEvt | input | 1 | Pulse: arbitration lost |
| genCallEvt | input | 1 | Pulse: general-call address accepted |
| sclStretch | input | 1 | Level: clock stretching in progress |
| clrMask | input | 5 | Write-one-to-clear mask for the flags |
| intEn | input | 5 | Per-flag interrupt enables |
| flags | output | 5 | Sticky event flags |
| busBusy | output | 1 | Bus active between START and STOP |
| sclHeldLow | output | 1 | SCL held low by stretching |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the collisions. A not-acknowledge pulse is placed in the very cycle a START is recognised, and a pulse is placed together with a software clear of the same bit. A design that lets clears win would lose that event, and the bench would see bit 2 at 0. It also wiggles SDA with SCL low, where a detector that ignores SCL would report false START and STOP conditions and flip `busBusy`. It checks that a STOP clears only the START flag and that a START clears the other four flags, so a swapped or shared self-clear rule shows up as a wrong flag vector.

// File: rtl/i2cStatPkg.sv
package i2cStatPkg;
  localparam int NUM_FLAGS  = 5;
  localparam int FLAG_START = 0;
  localparam int FLAG_STOP  = 1;
  localparam int FLAG_NACK  = 2;
  localparam int FLAG_ARB   = 3;
  localparam int FLAG_GCALL = 4;

  // strobes from bus-condition control to the flag datapath
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
  } busEvt_t;
endpackage

// File: rtl/i2cBusCtrl.sv
module i2cBusCtrl
  import i2cStatPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    sclStretch,
  output busEvt_t evt,
  output logic    busBusy,
  output logic    sclHeldLow
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclSync;
  logic [LAST:0] sdaSync;
  logic          sclPrev;
  logic          sdaPrev;
  logic          sclQ;
  logic          sdaQ;

  // synchronizer chain, idle bus level is high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else begin
          sclSync[g] <= sclIn;
          sdaSync[g] <= sdaIn;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else begin
          sclSync[g] <= sclSync[g-1];
          sdaSync[g] <= sdaSync[g-1];
        end
      end
    end
  end

  assign sclQ = sclSync[LAST];
  assign sdaQ = sdaSync[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  // SDA edge while SCL stays high across both samples
  always_comb begin
    evt.startSeen = sclQ & sclPrev & sdaPrev & ~sdaQ;
    evt.stopSeen  = sclQ & sclPrev & ~sdaPrev & sdaQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busBusy    <= 1'b0;
      sclHeldLow <= 1'b0;
    end else begin
      if (evt.startSeen)     busBusy <= 1'b1;
      else if (evt.stopSeen) busBusy <= 1'b0;
      sclHeldLow <= sclStretch & ~sclQ;
    end
  end
endmodule

// File: rtl/i2cFlagBank.sv
module i2cFlagBank #(
  parameter int NFLAG = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NFLAG-1:0] setVec,
  input  logic [NFLAG-1:0] selfClrVec,
  input  logic [NFLAG-1:0] swClr,
  input  logic [NFLAG-1:0] intEn,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  for (genvar i = 0; i < NFLAG; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           flags[i] <= 1'b0;
      else if (setVec[i])                  flags[i] <= 1'b1;  // set wins
      else if (swClr[i] || selfClrVec[i])  flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & intEn);
endmodule

// File: rtl/i2cBusStatus.sv
module i2cBusStatus
  import i2cStatPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 nackEvt,
  input  logic                 arbLostEvt,
  input  logic                 genCallEvt,
  input  logic                 sclStretch,
  input  logic [NUM_FLAGS-1:0] clrMask,
  input  logic [NUM_FLAGS-1:0] intEn,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 busBusy,
  output logic                 sclHeldLow,
  output logic                 irq
);
  busEvt_t              busEvt;
  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] selfClrVec;

  i2cBusCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .sclStretch (sclStretch),
    .evt        (busEvt),
    .busBusy    (busBusy),
    .sclHeldLow (sclHeldLow)
  );

  always_comb begin
    setVec                 = '0;
    setVec[FLAG_START]     = busEvt.startSeen;
    setVec[FLAG_STOP]      = busEvt.stopSeen;
    setVec[FLAG_NACK]      = nackEvt;
    setVec[FLAG_ARB]       = arbLostEvt;
    setVec[FLAG_GCALL]     = genCallEvt;
    // START flag drops on STOP; every other flag drops on START
    selfClrVec             = {NUM_FLAGS{busEvt.startSeen}};
    selfClrVec[FLAG_START] = busEvt.stopSeen;
  end

  i2cFlagBank #(.NFLAG(NUM_FLAGS)) uFlags (
    .clk        (clk),
    .rstN       (rstN),
    .setVec     (setVec),
    .selfClrVec (selfClrVec),
    .swClr      (clrMask),
    .intEn      (intEn),
    .flags      (flags),
    .irq        (irq)
  );
endmodule

// File: rtl/i2cBusStatusChk.sv
module i2cBusStatusChk
  import i2cStatPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input busEvt_t              evt,
  input logic                 nackEvt,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] intEn,
  input logic                 busBusy,
  input logic                 irq
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    evt.startSeen |=> busBusy);
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopSeen |=> !busBusy);
  p_start_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    evt.startSeen |=> flags[FLAG_START]);
  p_stop_clears_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopSeen |=> !flags[FLAG_START]);
  p_start_clears_nack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evt.startSeen && !nackEvt) |=> !flags[FLAG_NACK]);
  p_nack_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    nackEvt |=> flags[FLAG_NACK]);
  p_stop_flag_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_STOP]) |-> $past(evt.stopSeen));
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & intEn) == '0) |-> !irq);
  p_one_cond_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(evt.startSeen && evt.stopSeen));
endmodule

bind i2cBusStatus i2cBusStatusChk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .evt     (busEvt),
  .nackEvt (nackEvt),
  .flags   (flags),
  .intEn   (intEn),
  .busBusy (busBusy),
  .irq     (irq)
);

// File: tb/tb_i2cBusStatus.sv
`timescale 1ns/1ps
module tb_i2cBusStatus;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b1, sdaIn = 1'b1;
  logic       nackEvt = 1'b0, arbLostEvt = 1'b0, genCallEvt = 1'b0;
  logic       sclStretch = 1'b0;
  logic [4:0] clrMask = '0, intEn = '0;
  logic [4:0] flags;
  logic       busBusy, sclHeldLow, irq;
  int         nChecks = 0, nFails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  i2cBusStatus dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .nackEvt(nackEvt), .arbLostEvt(arbLostEvt), .genCallEvt(genCallEvt),
    .sclStretch(sclStretch), .clrMask(clrMask), .intEn(intEn),
    .flags(flags), .busBusy(busBusy), .sclHeldLow(sclHeldLow), .irq(irq)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStart();
    sclIn = 1'b0; waitCyc(4);
    sdaIn = 1'b1; waitCyc(4);
    sclIn = 1'b1; waitCyc(4);
    sdaIn = 1'b0; waitCyc(5);
  endtask

  task automatic doStop();
    sclIn = 1'b0; waitCyc(4);
    sdaIn = 1'b0; waitCyc(4);
    sclIn = 1'b1; waitCyc(4);
    sdaIn = 1'b1; waitCyc(5);
  endtask

  task automatic pulse(input int which);
    case (which)
      2: nackEvt = 1'b1;
      3: arbLostEvt = 1'b1;
      default: genCallEvt = 1'b1;
    endcase
    waitCyc(1);
    nackEvt = 1'b0; arbLostEvt = 1'b0; genCallEvt = 1'b0;
    waitCyc(1);
  endtask

  task automatic tReset();
    check("R10 flags", flags, 5'b0);
    check("R10 busBusy", {4'b0, busBusy}, 5'b0);
    check("R10 sclHeldLow", {4'b0, sclHeldLow}, 5'b0);
    check("R10 irq", {4'b0, irq}, 5'b0);
  endtask

  task automatic tStartStop();
    doStart();
    check("R1 busy after START", {4'b0, busBusy}, 5'b1);
    check("R2 START flag", flags, 5'b00001);
    doStop();
    check("R1 idle after STOP", {4'b0, busBusy}, 5'b0);
    check("R3 STOP sets bit1 clears bit0", flags, 5'b00010);
  endtask

  task automatic tLatency();
    // START takes effect after the third rising edge
    sclIn = 1'b1; sdaIn = 1'b1; waitCyc(4);
    sdaIn = 1'b0; waitCyc(2);
    check("R1 busy not yet after two edges", {4'b0, busBusy}, 5'b0);
    waitCyc(1);
    check("R1 busy after third edge", {4'b0, busBusy}, 5'b1);
    waitCyc(2);
    doStop();
    clrMask = 5'b11111; waitCyc(1); clrMask = '0; waitCyc(1);
  endtask

  task automatic tEvents();
    doStop();
    check("R2 STOP flag", flags, 5'b00010);
    intEn = '0;
    pulse(2); pulse(3); pulse(4);
    check("R5 event flags", flags, 5'b11110);
    check("R8 irq gated off", {4'b0, irq}, 5'b0);
    intEn = 5'b00100; waitCyc(1);
    check("R8 irq with nack enabled", {4'b0, irq}, 5'b1);
    intEn = 5'b00001; waitCyc(1);
    check("R8 irq enable on clear flag", {4'b0, irq}, 5'b0);
    intEn = '0;
  endtask

  task automatic tStartClears();
    doStart();
    check("R4 START clears bits 1-4", flags, 5'b00001);
  endtask

  task automatic tSwClear();
    pulse(2);
    check("R6 nack set", flags, 5'b00101);
    clrMask = 5'b00100; waitCyc(1); clrMask = '0; waitCyc(1);
    check("R6 W1C bit2 only", flags, 5'b00001);
    waitCyc(3);
    check("R6 zero mask keeps", flags, 5'b00001);
    clrMask = 5'b00001; waitCyc(1); clrMask = '0; waitCyc(1);
    check("R6 W1C bit0", flags, 5'b00000);
  endtask

  task automatic tPriority();
    nackEvt = 1'b1; clrMask = 5'b00100; waitCyc(1);
    nackEvt = 1'b0; clrMask = '0; waitCyc(1);
    check("R7 set beats W1C", flags, 5'b00100);
    doStop();
    check("R7 pre state", flags, 5'b00110);
    // nack pulse lined up with START recognition (third edge)
    sdaIn = 1'b0; waitCyc(2);
    nackEvt = 1'b1; waitCyc(1); nackEvt = 1'b0; waitCyc(1);
    check("R7 set beats START self-clear", flags, 5'b00101);
  endtask

  task automatic tSclLowSda();
    // bus busy now
    sclIn = 1'b0; waitCyc(4);
    sdaIn = 1'b1; waitCyc(4);
    sdaIn = 1'b0; waitCyc(4);
    sdaIn = 1'b1; waitCyc(4);
    check("R11 busy kept", {4'b0, busBusy}, 5'b1);
    check("R11 flags kept", flags, 5'b00101);
  endtask

  task automatic tHeldLow();
    sclIn = 1'b0; sclStretch = 1'b1; waitCyc(5);
    check("R9 held low", {4'b0, sclHeldLow}, 5'b1);
    sclStretch = 1'b0; waitCyc(2);
    check("R9 no stretch", {4'b0, sclHeldLow}, 5'b0);
    sclStretch = 1'b1; sclIn = 1'b1; waitCyc(5);
    check("R9 scl high", {4'b0, sclHeldLow}, 5'b0);
    sclStretch = 1'b0;
  endtask

  initial begin
    waitCyc(3);
    tReset();
    rstN = 1'b1; waitCyc(2);
    tReset();
    tStartStop();
    tLatency();
    tEvents();
    tStartClears();
    tSwClear();
    tPriority();
    tSclLowSda();
    tHeldLow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule